// File: doc/BRIEF.md
# Framebuffer Scan Address Generator

This block produces the word read addresses that fetch a linear, packed-pixel framebuffer one displayed line at a time. At the start of each frame it latches a software-supplied base address, the active line width in pixels and the pixel mode. On each active-line strobe from the display timing logic it issues one read request for each 32-bit word of that line and then moves its line pointer on by one line stride. Moving the image vertically, or flipping between two pages, is done only by writing a different base address. The new value is used from the next frame start, so a page flip never lands in the middle of a frame.

A second, independent path takes the 32-bit words returned by memory and splits them into pixels. It delivers one pixel per clock, starting at the least significant end of each word. It accepts the next word in the same cycle as the last pixel of the current one, so pixels can stream without gaps.

Pixel mode encoding on `pixMode`: 0 = off, 1 = 8 bits per pixel, 2 = 16 bits per pixel, 3 = 32 bits per pixel. The 24-bit colour format is stored with 32-bit pixels.

Top module: `scanAddrGen`

## Requirements
- R1: While reset is held, and right after it is released, `reqValid` and `pixValid` are 0 and `wordReady` is 1.
- R2: A `frameStart` pulse latches `baseAddr` with its two least significant bits cleared, whatever the state of `enable`. The first request of the first line of the frame uses that word-aligned address.
- R3: Changing `baseAddr` between frame starts has no effect on the current frame. The new value is used from the next `frameStart`.
- R4: An accepted line issues `activeWidth/4` words in mode 1, `activeWidth/2` words in mode 2 and `activeWidth` words in mode 3. The words go out at consecutive addresses 4 bytes apart. `reqAddr` holds steady while `reqValid` is high and `reqReady` is low.
- R5: Each accepted line after the first in a frame starts `activeWidth × bytes-per-pixel` bytes above the start of the line before it. The pixel size is 1, 2 or 4 bytes for modes 1, 2 and 3.
- R6: `pixMode` and `activeWidth` are sampled at `frameStart` and hold for the whole frame. In a frame latched with mode 0, `lineStart` is ignored and no requests are issued.
- R7: `reqValid` is low in any cycle where `enable` is low. A cycle with `enable` low throws away the rest of the line being fetched. A `lineStart` seen while `enable` is low is ignored and does not move the line pointer.
- R8: A `lineStart` that arrives while the previous line still has words outstanding drops those words and starts the next line.
- R9: When `frameStart` and `lineStart` are high in the same cycle, the line starts at the newly latched base, with the newly latched mode and width.
- R10: Each accepted word yields 4, 2 or 1 pixels in modes 1, 2 and 3. The pixels come out in order from the least significant end, one per cycle, zero-extended on `pixel`.
- R11: `wordReady` is high when at most one pixel of the current word is left. Back-to-back words in mode 3 therefore give one pixel in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Display enable; when low, requests stop |
| frameStart | input | 1 | One-cycle pulse at the start of a frame |
| lineStart | input | 1 | One-cycle pulse at the start of each active line |
| pixMode | input | 2 | Pixel mode: 0 off, 1 8-bit, 2 16-bit, 3 32-bit |
| activeWidth | input | 12 | Active pixels per line |
| baseAddr | input | 32 | Framebuffer base byte address |
| reqReady | input | 1 | Memory side accepts the current request |
| reqValid | output | 1 | A read request is pending |
| reqAddr | output | 32 | Word-aligned read byte address |
| wordValid | input | 1 | A fetched word is offered |
| wordIn | input | 32 | Fetched data word |
| wordReady | output | 1 | The unpacker takes `wordIn` this cycle |
| pixValid | output | 1 | `pixel` holds a valid pixel |
| pixel | output | 32 | Current pixel, zero-extended |

## Verification
The address path is run in all three pixel modes, with `reqReady` held high and with `reqReady` toggling. This separates errors in the word count from errors in the handshake hold. Base writes in the middle of a frame, frame and line strobes in the same cycle, and line strobes while the previous line is still busy each tell a correct line-pointer update apart from one that reads its inputs at the wrong time. Dropping `enable` partway through a line shows whether the rest of the line is cancelled and whether a strobe during the disabled time wrongly moves the line pointer. On the pixel side, single words in each mode show the extraction order, and streaming words in mode 3 shows whether the unpacker loses a cycle between words.

// File: rtl/scanPkg.sv
package scanPkg;

  typedef struct packed {
    logic frameLoad;
    logic lineLoad;
    logic reqAdvance;
    logic wordLoad;
    logic pixShift;
  } scanStrobe_t;

  function automatic logic [2:0] pixPerWord(input logic [1:0] mode);
    case (mode)
      2'd1:    pixPerWord = 3'd4;
      2'd2:    pixPerWord = 3'd2;
      2'd3:    pixPerWord = 3'd1;
      default: pixPerWord = 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/scanCtrl.sv
module scanCtrl
  import scanPkg::*;
#(
  parameter int WIDTH_W = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic               frameStart,
  input  logic               lineStart,
  input  logic               reqReady,
  input  logic               wordValid,
  input  logic               effModeOn,
  input  logic [WIDTH_W-1:0] effLineWords,
  input  logic [2:0]         curPixPerWord,
  output logic               reqValid,
  output logic               wordReady,
  output logic               pixValid,
  output scanStrobe_t        strobe
);

  logic [WIDTH_W-1:0] wordsLeft;
  logic [2:0]         pixLeft;
  logic               lineLoad;
  logic               reqAdvance;
  logic               wordLoad;

  assign lineLoad   = enable && lineStart && effModeOn;
  assign reqValid   = enable && (wordsLeft != '0);
  assign reqAdvance = reqValid && reqReady;

  assign wordReady  = (pixLeft <= 3'd1);
  assign wordLoad   = wordValid && wordReady;
  assign pixValid   = (pixLeft != 3'd0);

  always_comb begin
    strobe            = '0;
    strobe.frameLoad  = frameStart;
    strobe.lineLoad   = lineLoad;
    strobe.reqAdvance = reqAdvance;
    strobe.wordLoad   = wordLoad;
    strobe.pixShift   = pixValid && !wordLoad;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordsLeft <= '0;
    end else if (!enable) begin
      wordsLeft <= '0;
    end else if (lineLoad) begin
      wordsLeft <= effLineWords;
    end else if (reqAdvance) begin
      wordsLeft <= wordsLeft - WIDTH_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pixLeft <= 3'd0;
    end else if (wordLoad) begin
      pixLeft <= curPixPerWord;
    end else if (pixValid) begin
      pixLeft <= pixLeft - 3'd1;
    end
  end

  AST_LINE_ISSUES: assert property (@(posedge clk) disable iff (!rstN) (lineLoad && effLineWords != '0) |=> (reqValid || !enable)); // R4
  AST_WORD_TO_PIX: assert property (@(posedge clk) disable iff (!rstN) (wordLoad && curPixPerWord != 3'd0) |=> pixValid); // R10

endmodule

// File: rtl/scanDatapath.sv
module scanDatapath
  import scanPkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int WIDTH_W = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               frameStart,
  input  logic [1:0]         pixMode,
  input  logic [WIDTH_W-1:0] activeWidth,
  input  logic [ADDR_W-1:0]  baseAddr,
  input  logic [31:0]        wordIn,
  input  scanStrobe_t        strobe,
  output logic               effModeOn,
  output logic [WIDTH_W-1:0] effLineWords,
  output logic [2:0]         curPixPerWord,
  output logic [ADDR_W-1:0]  reqAddr,
  output logic [31:0]        pixel
);

  logic [1:0]         curMode;
  logic [WIDTH_W-1:0] curWidth;
  logic [ADDR_W-1:0]  lineAddr;
  logic [ADDR_W-1:0]  fetchAddr;
  logic [31:0]        shiftReg;

  logic [1:0]         effMode;
  logic [WIDTH_W-1:0] effWidth;
  logic [ADDR_W-1:0]  alignedBase;
  logic [ADDR_W-1:0]  startAddr;
  logic [ADDR_W-1:0]  strideBytes;

  assign effMode     = frameStart ? pixMode : curMode;
  assign effWidth    = frameStart ? activeWidth : curWidth;
  assign effModeOn   = (effMode != 2'd0);
  assign alignedBase = baseAddr & ~ADDR_W'(3);
  assign startAddr   = frameStart ? alignedBase : lineAddr;

  always_comb begin
    case (effMode)
      2'd1:    effLineWords = effWidth >> 2;
      2'd2:    effLineWords = effWidth >> 1;
      2'd3:    effLineWords = effWidth;
      default: effLineWords = '0;
    endcase
  end

  assign strideBytes   = ADDR_W'({effLineWords, 2'b00});
  assign curPixPerWord = pixPerWord(curMode);
  assign reqAddr       = fetchAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curMode   <= 2'd0;
      curWidth  <= '0;
      lineAddr  <= '0;
      fetchAddr <= '0;
    end else begin
      if (strobe.frameLoad) begin
        curMode  <= pixMode;
        curWidth <= activeWidth;
        lineAddr <= alignedBase;
      end
      if (strobe.lineLoad) begin
        fetchAddr <= startAddr;
        lineAddr  <= startAddr + strideBytes;
      end else if (strobe.reqAdvance) begin
        fetchAddr <= fetchAddr + ADDR_W'(4);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strobe.wordLoad) begin
      shiftReg <= wordIn;
    end else if (strobe.pixShift) begin
      case (curMode)
        2'd1:    shiftReg <= shiftReg >> 8;
        2'd2:    shiftReg <= shiftReg >> 16;
        default: shiftReg <= '0;
      endcase
    end
  end

  always_comb begin
    case (curMode)
      2'd1:    pixel = {24'd0, shiftReg[7:0]};
      2'd2:    pixel = {16'd0, shiftReg[15:0]};
      default: pixel = shiftReg;
    endcase
  end

endmodule

// File: rtl/scanAddrGen.sv
module scanAddrGen
  import scanPkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int WIDTH_W = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic               frameStart,
  input  logic               lineStart,
  input  logic [1:0]         pixMode,
  input  logic [WIDTH_W-1:0] activeWidth,
  input  logic [ADDR_W-1:0]  baseAddr,
  input  logic               reqReady,
  output logic               reqValid,
  output logic [ADDR_W-1:0]  reqAddr,
  input  logic               wordValid,
  input  logic [31:0]        wordIn,
  output logic               wordReady,
  output logic               pixValid,
  output logic [31:0]        pixel
);

  scanStrobe_t        strobe;
  logic               effModeOn;
  logic [WIDTH_W-1:0] effLineWords;
  logic [2:0]         curPixPerWord;

  scanCtrl #(.WIDTH_W(WIDTH_W)) i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .enable       (enable),
    .frameStart   (frameStart),
    .lineStart    (lineStart),
    .reqReady     (reqReady),
    .wordValid    (wordValid),
    .effModeOn    (effModeOn),
    .effLineWords (effLineWords),
    .curPixPerWord(curPixPerWord),
    .reqValid     (reqValid),
    .wordReady    (wordReady),
    .pixValid     (pixValid),
    .strobe       (strobe)
  );

  scanDatapath #(.ADDR_W(ADDR_W), .WIDTH_W(WIDTH_W)) i_dp (
    .clk          (clk),
    .rstN         (rstN),
    .frameStart   (frameStart),
    .pixMode      (pixMode),
    .activeWidth  (activeWidth),
    .baseAddr     (baseAddr),
    .wordIn       (wordIn),
    .strobe       (strobe),
    .effModeOn    (effModeOn),
    .effLineWords (effLineWords),
    .curPixPerWord(curPixPerWord),
    .reqAddr      (reqAddr),
    .pixel        (pixel)
  );

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN) (reqValid && !reqReady && !lineStart) |=> (!enable || (reqValid && $stable(reqAddr)))); // R4
  AST_REQ_STEP: assert property (@(posedge clk) disable iff (!rstN) (reqValid && reqReady && !lineStart) |=> (!reqValid || reqAddr == $past(reqAddr) + ADDR_W'(4))); // R4
  AST_OFF_CANCELS: assert property (@(posedge clk) disable iff (!rstN) !enable |=> !reqValid); // R7

endmodule

// File: tb/test_scanAddrGen.sv
module test_scanAddrGen;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic        frameStart = 1'b0;
  logic        lineStart = 1'b0;
  logic [1:0]  pixMode = 2'd0;
  logic [11:0] activeWidth = 12'd0;
  logic [31:0] baseAddr = 32'd0;
  logic        reqReady = 1'b0;
  logic        wordValid = 1'b0;
  logic [31:0] wordIn = 32'd0;
  logic        reqValid;
  logic [31:0] reqAddr;
  logic        wordReady;
  logic        pixValid;
  logic [31:0] pixel;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  scanAddrGen i_scanAddrGen (
    .clk(clk), .rstN(rstN), .enable(enable), .frameStart(frameStart),
    .lineStart(lineStart), .pixMode(pixMode), .activeWidth(activeWidth),
    .baseAddr(baseAddr), .reqReady(reqReady), .reqValid(reqValid),
    .reqAddr(reqAddr), .wordValid(wordValid), .wordIn(wordIn),
    .wordReady(wordReady), .pixValid(pixValid), .pixel(pixel)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference model: queues of expected request addresses and pixels
  logic [31:0] aq[$];
  logic [31:0] pq[$];
  int          rMode = 0;
  int          rWidth = 0;
  longint      rLine = 0;

  function automatic int wordsFor(int m, int w);
    if (m == 1) return w / 4;
    if (m == 2) return w / 2;
    if (m == 3) return w;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      aq.delete(); pq.delete(); rMode = 0; rWidth = 0; rLine = 0;
    end else begin
      bit acc;
      bit popOk;
      acc   = wordValid && (pq.size() <= 1);
      popOk = enable && (aq.size() != 0) && reqReady;
      if (pq.size() != 0) void'(pq.pop_front());
      if (acc) begin
        int n;
        int b;
        n = (rMode == 1) ? 4 : (rMode == 2) ? 2 : (rMode == 3) ? 1 : 0;
        b = 32 / ((n == 0) ? 1 : n);
        for (int k = 0; k < n; k++) begin
          longint v;
          v = (longint'(wordIn) >> (k * b)) & ((longint'(1) << b) - 1);
          pq.push_back(v[31:0]);
        end
      end
      if (frameStart) begin
        rMode  = pixMode;
        rWidth = activeWidth;
        rLine  = baseAddr & 32'hFFFF_FFFC;
      end
      if (!enable) aq.delete();
      else if (lineStart && rMode != 0) begin
        int nw;
        aq.delete();
        nw = wordsFor(rMode, rWidth);
        for (int k = 0; k < nw; k++) begin
          longint a;
          a = rLine + 4 * k;
          aq.push_back(a[31:0]);
        end
        rLine = rLine + 4 * nw;
      end else if (popOk) void'(aq.pop_front());
    end
    #1;
    if (rstN && !done) begin
      bit expV;
      expV = enable && (aq.size() != 0);
      chk(reqValid === expV, enable ? "R4 reqValid" : "R7 reqValid while disabled", {31'd0, reqValid}, {31'd0, expV});
      if (expV) chk(reqAddr === aq[0], "R5 reqAddr", reqAddr, aq[0]);
      chk(pixValid === (pq.size() != 0), "R10 pixValid", {31'd0, pixValid}, {31'd0, pq.size() != 0});
      if (pq.size() != 0) chk(pixel === pq[0], "R10 pixel", pixel, pq[0]);
      chk(wordReady === (pq.size() <= 1), "R11 wordReady", {31'd0, wordReady}, {31'd0, pq.size() <= 1});
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseFrame();
    frameStart = 1'b1; @(negedge clk); frameStart = 1'b0;
  endtask

  task automatic pulseLine();
    lineStart = 1'b1; @(negedge clk); lineStart = 1'b0;
  endtask

  task automatic countWords(input bit toggle, output int cnt);
    cnt = 0;
    for (int i = 0; i < 40; i++) begin
      if (toggle) reqReady = i[0];
      #1;
      if (reqValid && reqReady) cnt++;
      @(negedge clk);
    end
    reqReady = 1'b1;
  endtask

  task automatic finishRun();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    finishRun();
  end

  initial begin
    int cnt;
    step(3);
    chk(!reqValid && !pixValid && wordReady, "R1 reset state", {29'd0, reqValid, pixValid, wordReady}, 32'd1);
    rstN = 1'b1;
    step(1);
    chk(!reqValid && !pixValid && wordReady, "R1 after release", {29'd0, reqValid, pixValid, wordReady}, 32'd1);

    enable = 1; pixMode = 1; activeWidth = 16; baseAddr = 32'h1003; reqReady = 0;
    pulseFrame(); pulseLine();
    chk(reqValid && reqAddr == 32'h1000, "R2 aligned base", reqAddr, 32'h1000);
    reqReady = 1; step(6); reqReady = 0; pulseLine();
    chk(reqAddr == 32'h1010, "R5 8-bit stride", reqAddr, 32'h1010);
    baseAddr = 32'h8000; reqReady = 1; step(6); reqReady = 0; pulseLine();
    chk(reqAddr == 32'h1020, "R3 mid-frame base ignored", reqAddr, 32'h1020);
    reqReady = 1; step(6); reqReady = 0; pulseFrame(); pulseLine();
    chk(reqAddr == 32'h8000, "R3 base used at next frame", reqAddr, 32'h8000);
    reqReady = 1; step(6);

    pixMode = 2; pulseFrame(); pulseLine(); countWords(0, cnt);
    chk(cnt == 8, "R4 16-bit word count", cnt, 8);
    pixMode = 3; pulseFrame(); pulseLine(); countWords(1, cnt);
    chk(cnt == 16, "R4 32-bit word count with stalls", cnt, 16);
    reqReady = 0; pulseLine();
    chk(reqAddr == 32'h8040, "R5 32-bit stride", reqAddr, 32'h8040);
    reqReady = 1; pixMode = 1; pulseLine(); countWords(0, cnt);
    chk(cnt == 16, "R6 mode held for frame", cnt, 16);
    pixMode = 0; pulseFrame(); pulseLine(); step(2);
    chk(!reqValid, "R6 mode 0 no requests", {31'd0, reqValid}, 32'd0);

    pixMode = 1; baseAddr = 32'h2000; pulseFrame(); reqReady = 0; pulseLine();
    reqReady = 1; step(1); enable = 0; #1;
    chk(!reqValid, "R7 request drops with enable", {31'd0, reqValid}, 32'd0);
    step(2); enable = 1; #1;
    chk(!reqValid, "R7 line cancelled", {31'd0, reqValid}, 32'd0);
    enable = 0; pulseLine(); enable = 1; reqReady = 0; pulseLine();
    chk(reqAddr == 32'h2010, "R7 disabled lineStart no advance", reqAddr, 32'h2010);
    pulseLine();
    chk(reqAddr == 32'h2020, "R8 restart while busy", reqAddr, 32'h2020);
    reqReady = 1; countWords(0, cnt);
    chk(cnt == 4, "R8 old words dropped", cnt, 4);

    baseAddr = 32'h3000; reqReady = 0;
    frameStart = 1; lineStart = 1; @(negedge clk); frameStart = 0; lineStart = 0;
    chk(reqAddr == 32'h3000, "R9 same-cycle frame and line", reqAddr, 32'h3000);
    reqReady = 1; step(6); reqReady = 0; pulseLine();
    chk(reqAddr == 32'h3010, "R9 following line", reqAddr, 32'h3010);
    reqReady = 1; step(6);

    wordValid = 1; wordIn = 32'h44332211; @(negedge clk); wordValid = 0;
    chk(pixValid && pixel == 32'h11, "R10 8-bit first pixel", pixel, 32'h11);
    step(1);
    chk(pixValid && pixel == 32'h22, "R10 8-bit second pixel", pixel, 32'h22);
    step(4);

    pixMode = 3; pulseFrame();
    cnt = 0;
    for (int k = 0; k < 3; k++) begin
      wordValid = 1; wordIn = 32'hA000_0000 + k;
      @(negedge clk);
      if (pixValid) cnt++;
    end
    wordValid = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (pixValid) cnt++;
    end
    chk(cnt == 3, "R11 back-to-back 32-bit", cnt, 3);

    pixMode = 2; pulseFrame();
    wordValid = 1; wordIn = 32'hA0B0C0D0; @(negedge clk); wordValid = 0;
    chk(pixValid && pixel == 32'hC0D0, "R10 16-bit low half", pixel, 32'hC0D0);
    step(1);
    chk(pixValid && pixel == 32'hA0B0, "R10 16-bit high half", pixel, 32'hA0B0);
    step(3);
    finishRun();
  end

endmodule